// File: doc/BRIEF.md
# Block-Length SPI Master with Word FIFO

This block is a serial-peripheral master that sits on a simple 32-bit register bus. Software writes a byte count and then a control word. The control word carries a start flag, a direction, a clock-rate code and a chip-select number. The block then moves exactly that many bytes over SCLK/MOSI/MISO. Data crosses the bus as 32-bit words through one FIFO data register, and an eight-word FIFO stands between the bus and the shift register.

Software moves data in chunks of up to eight words. Before each chunk it polls a single status bit, and it polls that bit only at chunk boundaries. Several blocks can be started one after another while the chosen chip-select line stays low. A write to a separate done register ends the sequence and raises every chip-select line.

Top module: `spi_blk_master`

## Requirements
- R1: The registers sit at byte offsets 0x00 control, 0x04 done, 0x08 block length, 0x0C FIFO data and 0x10 status. In control, bits 2:0 are the rate code, bits 7:6 are the chip-select number and bit 13 is the direction (1 = transmit, 0 = receive). Control and block length read back what was written, and all registers read 0 after reset.
- R2: Writing control with bit 15 set and a nonzero block length starts a block. Control bit 15 then reads 1 until the falling SCLK edge of the last bit of the last byte, and reads 0 from then on.
- R3: SCLK idles low. MOSI changes on falling edges and MISO is sampled on rising edges (mode 0), with each byte sent MSB first. With rate code n, SCLK is high for 2^(n+1) clocks and low for 2^(n+1) clocks within a byte.
- R4: On a transmit block, each FIFO word is sent least-significant byte first, and exactly block-length bytes leave the pin. Unused bytes of the final word are dropped. SCLK stalls low while the FIFO has no word to give.
- R5: On a receive block, MOSI is held at 1 for every bit. Received bytes are packed least-significant byte first into FIFO words, and the unused upper bytes of a final partial word read 0.
- R6: The FIFO holds 8 words. Status bit 0 reads 1 while the FIFO is not ready for the next chunk. On a transmit block that means the FIFO is not empty. On a receive block it means the FIFO holds fewer than min(8, words not yet read) words.
- R7: Chip-select number k (0 to 2) drives spi_cs_n[k] low from the start of a block. It stays low across later blocks until any write to offset 0x04, which raises every line on the next cycle. At most one line is low at a time, and SCLK is high only while a line is low.
- R8: Reading the FIFO data register while the FIFO is empty returns the last word popped and does not change the FIFO state.
- R9: A start with block length 0 completes at once. Control bit 15 reads 0 on the next cycle and SCLK never toggles.
- R10: A control write while a block is in progress is ignored entirely, including its start flag and its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per access |
| reg_rd_en | input | 1 | Register read strobe; pops the FIFO when it addresses the data register |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |
| spi_cs_n | output | NUM_CS (3) | Active-low chip-select lines |

## Verification
The hardest states to reach are those where the FIFO, rather than the pin, sets the pace. Examples are a transmit block that outruns its eight-word chunk, or a receive block whose status bit must wait for a short final word. The bench drives blocks of 36 and 40 bytes, so software has to refill or drain the FIFO in several chunks gated by the status bit. It also uses lengths that are not a multiple of four. A peripheral model in the bench replays MISO bytes and compares every MOSI byte against a queue the driver filled. A control write is issued while a slow block is still shifting, to show that a mid-block start has no effect.

// File: rtl/spim_pkg.sv
// Shared constants for the block-length SPI master: register offsets,
// control-field positions and the serialiser state type.
package spim_pkg;
    localparam int REG_AW = 5;
    localparam logic [REG_AW-1:0] OFF_CTRL = 5'h00;
    localparam logic [REG_AW-1:0] OFF_DONE = 5'h04;
    localparam logic [REG_AW-1:0] OFF_BLEN = 5'h08;
    localparam logic [REG_AW-1:0] OFF_FIFO = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_STAT = 5'h10;

    localparam int CTRL_GO_BIT  = 15;
    localparam int CTRL_DIR_BIT = 13;
    localparam int CTRL_CS_LSB  = 6;
    localparam int RATE_W       = 3;
    localparam int CS_W         = 2;

    typedef enum logic [1:0] {
        SD_IDLE,
        SD_FETCH,
        SD_LOW,
        SD_HIGH
    } sd_state_e;
endpackage

// File: rtl/spim_fifo.sv
// Word FIFO between the register bus and the serialiser.
// Assumes DEPTH is a power of two of at least 2. A push when full and a pop
// when empty are dropped. Flush empties the FIFO and takes priority.
module spim_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          pop_i,
    output logic [W-1:0]  rdata_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          do_push, do_pop;

    assign full_o  = (count_q == CW'(DEPTH));
    assign empty_o = (count_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rdata_o = mem_q[rd_ptr_q];
    assign count_o = count_q;

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + PW'(1);
            if (do_pop)  rd_ptr_q <= rd_ptr_q + PW'(1);
            if (do_push && !do_pop)      count_q <= count_q + CW'(1);
            else if (do_pop && !do_push) count_q <= count_q - CW'(1);
        end
    end

    // R6
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !flush_i) |=> full_o);

    // R8
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/spim_serdes.sv
// Serialiser with a built-in clock divider. It moves len_i bytes in mode 0,
// MSB first. Transmit words come from the FIFO, least-significant byte first.
// Receive bytes are packed into words the same way and pushed to the FIFO.
// Assumes start_i is pulsed only while busy_o is low and len_i is nonzero.
module spim_serdes import spim_pkg::*; #(
    parameter int LEN_W = 16,
    localparam int DIV_W = (1 << RATE_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              dir_wr_i,
    input  logic              fifo_empty_i,
    input  logic              fifo_full_i,
    input  logic [31:0]       fifo_rdata_i,
    output logic              fifo_pop_o,
    output logic              fifo_push_o,
    output logic [31:0]       fifo_wdata_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              busy_o
);
    sd_state_e         st_q;
    logic [DIV_W-1:0]  cnt_q, half_m1_q;
    logic [LEN_W-1:0]  left_q;
    logic [2:0]        bidx_q;
    logic [1:0]        byix_q;
    logic              wr_q;
    logic [31:0]       word_q, rxw_q, rxw_next;
    logic [7:0]        tx_q, rx_q;
    logic              phase_end, last_byte, byte_done;
    logic [1:0]        pad;

    assign phase_end    = (cnt_q == half_m1_q);
    assign last_byte    = (left_q == LEN_W'(1));
    assign byte_done    = (st_q == SD_HIGH) && phase_end && (bidx_q == 3'd7);
    assign rxw_next     = {rx_q, rxw_q[31:8]};
    assign pad          = 2'd3 - byix_q;
    assign fifo_wdata_o = rxw_next >> {pad, 3'b000};
    assign fifo_pop_o   = (st_q == SD_FETCH) && wr_q && !fifo_empty_i;
    assign fifo_push_o  = byte_done && !wr_q && ((byix_q == 2'd3) || last_byte);
    assign sclk_o       = (st_q == SD_HIGH);
    assign mosi_o       = tx_q[7];
    assign busy_o       = (st_q != SD_IDLE);

    // Sequencer: word fetch, half-period timing, bit and byte stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SD_IDLE;
            cnt_q     <= '0;
            half_m1_q <= '0;
            left_q    <= '0;
            bidx_q    <= '0;
            byix_q    <= '0;
            wr_q      <= 1'b0;
            word_q    <= '0;
            rxw_q     <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
        end else begin
            unique case (st_q)
                SD_IDLE: begin
                    if (start_i) begin
                        left_q    <= len_i;
                        wr_q      <= dir_wr_i;
                        half_m1_q <= (DIV_W'(1) << ({1'b0, rate_i} + (RATE_W+1)'(1))) - DIV_W'(1);
                        byix_q    <= '0;
                        st_q      <= SD_FETCH;
                    end
                end
                SD_FETCH: begin
                    if (wr_q && !fifo_empty_i) begin
                        word_q <= fifo_rdata_i >> 8;
                        tx_q   <= fifo_rdata_i[7:0];
                        cnt_q  <= '0;
                        bidx_q <= '0;
                        st_q   <= SD_LOW;
                    end else if (!wr_q && !fifo_full_i) begin
                        tx_q   <= 8'hFF;
                        rxw_q  <= '0;
                        cnt_q  <= '0;
                        bidx_q <= '0;
                        st_q   <= SD_LOW;
                    end
                end
                SD_LOW: begin
                    if (phase_end) begin
                        rx_q  <= {rx_q[6:0], miso_i};
                        cnt_q <= '0;
                        st_q  <= SD_HIGH;
                    end else begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end
                end
                SD_HIGH: begin
                    if (!phase_end) begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end else begin
                        cnt_q <= '0;
                        if (bidx_q != 3'd7) begin
                            bidx_q <= bidx_q + 3'd1;
                            tx_q   <= {tx_q[6:0], 1'b0};
                            st_q   <= SD_LOW;
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                            if (!wr_q) rxw_q <= rxw_next;
                            if (last_byte) begin
                                st_q <= SD_IDLE;
                            end else if (byix_q == 2'd3) begin
                                byix_q <= '0;
                                st_q   <= SD_FETCH;
                            end else begin
                                byix_q <= byix_q + 2'd1;
                                bidx_q <= '0;
                                tx_q   <= wr_q ? word_q[7:0] : 8'hFF;
                                word_q <= word_q >> 8;
                                st_q   <= SD_LOW;
                            end
                        end
                    end
                end
                default: st_q <= SD_IDLE;
            endcase
        end
    end

    // R4
    write_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SD_FETCH && wr_q && fifo_empty_i) |=> !sclk_o);

    // R5
    read_mosi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == SD_LOW || st_q == SD_HIGH) && !wr_q) |-> mosi_o);
endmodule

// File: rtl/spi_blk_master.sv
// Register-mapped SPI master. Holds the control, length, done, FIFO and
// status registers, routes the word FIFO between the bus and the
// serialiser, and keeps the chip-select line low until a done write.
// Assumes single-cycle register accesses and a power-of-two FIFO_WORDS.
module spi_blk_master import spim_pkg::*; #(
    parameter int LEN_W      = 16,
    parameter int FIFO_WORDS = 8,
    parameter int NUM_CS     = 3,
    localparam int CNT_W     = $clog2(FIFO_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    logic [RATE_W-1:0] rate_q;
    logic [CS_W-1:0]   csf_q, cs_sel_q;
    logic              dir_q, cs_act_q;
    logic [LEN_W-1:0]  blen_q, rd_left_q;
    logic [31:0]       last_rd_q;

    logic wr_ctrl, wr_done, wr_blen, wr_fifo, rd_fifo, start_acc;
    logic sd_busy, sd_pop, sd_push;
    logic [31:0] sd_wdata, fifo_rdata;
    logic [CNT_W-1:0] fifo_count, need_words;
    logic fifo_full, fifo_empty, fifo_push, fifo_pop, not_ready, bus_pop;
    logic [31:0] fifo_push_data;

    assign wr_ctrl   = reg_wr_en && (reg_addr == OFF_CTRL);
    assign wr_done   = reg_wr_en && (reg_addr == OFF_DONE);
    assign wr_blen   = reg_wr_en && (reg_addr == OFF_BLEN);
    assign wr_fifo   = reg_wr_en && (reg_addr == OFF_FIFO);
    assign rd_fifo   = reg_rd_en && (reg_addr == OFF_FIFO);
    assign start_acc = wr_ctrl && reg_wdata[CTRL_GO_BIT] && !sd_busy;

    assign fifo_push      = dir_q ? wr_fifo : sd_push;
    assign fifo_push_data = dir_q ? reg_wdata : sd_wdata;
    assign fifo_pop       = dir_q ? sd_pop : rd_fifo;
    assign bus_pop        = rd_fifo && !dir_q && !fifo_empty;

    assign need_words = (rd_left_q >= LEN_W'(FIFO_WORDS)) ? CNT_W'(FIFO_WORDS)
                                                          : CNT_W'(rd_left_q);
    assign not_ready  = dir_q ? (fifo_count != '0) : (fifo_count < need_words);

    spim_fifo #(.W(32), .DEPTH(FIFO_WORDS)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (start_acc),
        .push_i  (fifo_push),
        .wdata_i (fifo_push_data),
        .pop_i   (fifo_pop),
        .rdata_o (fifo_rdata),
        .count_o (fifo_count),
        .full_o  (fifo_full),
        .empty_o (fifo_empty)
    );

    spim_serdes #(.LEN_W(LEN_W)) u_serdes (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_acc && (blen_q != '0)),
        .len_i        (blen_q),
        .rate_i       (reg_wdata[RATE_W-1:0]),
        .dir_wr_i     (reg_wdata[CTRL_DIR_BIT]),
        .fifo_empty_i (fifo_empty),
        .fifo_full_i  (fifo_full),
        .fifo_rdata_i (fifo_rdata),
        .fifo_pop_o   (sd_pop),
        .fifo_push_o  (sd_push),
        .fifo_wdata_o (sd_wdata),
        .sclk_o       (spi_sclk),
        .mosi_o       (spi_mosi),
        .miso_i       (spi_miso),
        .busy_o       (sd_busy)
    );

    // Control fields, length, chip-select state and receive bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q    <= '0;
            csf_q     <= '0;
            dir_q     <= 1'b0;
            blen_q    <= '0;
            cs_act_q  <= 1'b0;
            cs_sel_q  <= '0;
            rd_left_q <= '0;
            last_rd_q <= '0;
        end else begin
            if (wr_ctrl && !sd_busy) begin
                rate_q <= reg_wdata[RATE_W-1:0];
                csf_q  <= reg_wdata[CTRL_CS_LSB +: CS_W];
                dir_q  <= reg_wdata[CTRL_DIR_BIT];
            end
            if (wr_blen) blen_q <= reg_wdata[LEN_W-1:0];
            if (start_acc) begin
                cs_act_q  <= 1'b1;
                cs_sel_q  <= reg_wdata[CTRL_CS_LSB +: CS_W];
                rd_left_q <= LEN_W'(({1'b0, blen_q} + (LEN_W+1)'(3)) >> 2);
            end else if (bus_pop && rd_left_q != '0) begin
                rd_left_q <= rd_left_q - LEN_W'(1);
            end
            if (wr_done) cs_act_q <= 1'b0;
            if (bus_pop) last_rd_q <= fifo_rdata;
        end
    end

    // Active-low chip-select decode, one line per select number.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign spi_cs_n[g] = !(cs_act_q && (cs_sel_q == CS_W'(g)));
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_CTRL: begin
                reg_rdata[CTRL_GO_BIT]             = sd_busy;
                reg_rdata[CTRL_DIR_BIT]            = dir_q;
                reg_rdata[CTRL_CS_LSB +: CS_W]     = csf_q;
                reg_rdata[RATE_W-1:0]              = rate_q;
            end
            OFF_BLEN: reg_rdata = 32'(blen_q);
            OFF_FIFO: reg_rdata = fifo_empty ? last_rd_q : fifo_rdata;
            OFF_STAT: reg_rdata[0] = not_ready;
            default:  reg_rdata = '0;
        endcase
    end

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (&spi_cs_n));

    // R7
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R7
    sclk_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !(&spi_cs_n));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && blen_q != '0) |=> sd_busy);

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && blen_q == '0) |=> !sd_busy);

    // R10
    busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && sd_busy) |=> ($stable(rate_q) && $stable(csf_q) && $stable(dir_q)));
endmodule

// File: tb/spi_blk_master_tb.sv
`timescale 1ns/1ps
module spi_blk_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [2:0]  spi_cs_n;

    always #10 clk = ~clk;

    spi_blk_master u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    string cur_req = "R4";

    logic [7:0]  exp_mosi_q[$];
    logic [7:0]  miso_q[$];
    logic [31:0] tx_words[$];
    logic [7:0]  rx_bytes[$];

    logic [7:0] cur_miso = 8'h00;
    logic [2:0] bitcnt = '0;
    logic [7:0] mon_sh = '0;
    logic       sclk_prev = 1'b0;
    int cyc = 0, last_rise = 0, last_period = 0, rise_cnt = 0;

    assign spi_miso = cur_miso[3'd7 - bitcnt];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Peripheral model and scoreboard monitor for serial bytes.
    always @(negedge clk) begin
        cyc++;
        if (spi_sclk && !sclk_prev) begin
            rise_cnt++;
            if (bitcnt != 3'd0) last_period = cyc - last_rise;
            last_rise = cyc;
            mon_sh = {mon_sh[6:0], spi_mosi};
            if (bitcnt == 3'd7) begin
                bitcnt = 3'd0;
                if (exp_mosi_q.size() == 0) begin
                    check(cur_req, "unexpected MOSI byte", 32'(mon_sh), 32'hxx);
                end else begin
                    check(cur_req, "MOSI byte", 32'(mon_sh), 32'(exp_mosi_q.pop_front()));
                end
                cur_miso = (miso_q.size() != 0) ? miso_q.pop_front() : 8'h00;
            end else begin
                bitcnt = bitcnt + 3'd1;
            end
        end
        sclk_prev = spi_sclk;
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic wait_status_ready(input string req);
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            bus_read(5'h10, s);
            if (s[0] == 1'b0) return;
        end
        check(req, "status never ready", 32'd1, 32'd0);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] c;
        for (int i = 0; i < 20000; i++) begin
            bus_read(5'h00, c);
            if (c[15] == 1'b0) return;
        end
        check(req, "busy never cleared", 32'd1, 32'd0);
    endtask

    // Driver: transmit block from tx_words, expected bytes into scoreboard.
    task automatic run_write(input int cs, input int rate, input int len);
        logic [31:0] s;
        int nw, idx;
        cur_req = "R4";
        for (int i = 0; i < len; i++)
            exp_mosi_q.push_back(8'(tx_words[i/4] >> (8*(i%4))));
        bus_write(5'h08, 32'(len));
        bus_write(5'h00, 32'h0000_A000 | 32'(cs << 6) | 32'(rate));
        nw = (len + 3) / 4;
        idx = 0;
        while (idx < nw) begin
            int k = 0;
            wait_status_ready("R6");
            while (k < 8 && idx < nw) begin
                bus_write(5'h0C, tx_words[idx]);
                idx++; k++;
            end
            if (k >= 2) begin
                bus_read(5'h10, s);
                check("R6", "status busy after chunk push", 32'(s[0]), 32'd1);
            end
        end
        wait_idle("R2");
        check("R2", "all bytes sent when busy clears", 32'(exp_mosi_q.size()), 32'd0);
        check("R3", "SCLK low after block", 32'(spi_sclk), 32'd0);
    endtask

    // Driver: receive block of rx_bytes; compares words read from the FIFO.
    task automatic run_read(input int cs, input int rate, input int len);
        logic [31:0] exp_w[$];
        logic [31:0] s, d;
        int nw, idx;
        cur_req = "R5";
        nw = (len + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] v = '0;
            for (int b = 0; b < 4; b++)
                if (4*w + b < len) v |= 32'(rx_bytes[4*w+b]) << (8*b);
            exp_w.push_back(v);
        end
        for (int i = 0; i < len; i++) exp_mosi_q.push_back(8'hFF);
        cur_miso = rx_bytes[0];
        for (int i = 1; i < len; i++) miso_q.push_back(rx_bytes[i]);
        bus_write(5'h08, 32'(len));
        bus_write(5'h00, 32'h0000_8000 | 32'(cs << 6) | 32'(rate));
        bus_read(5'h10, s);
        check("R6", "status busy right after receive start", 32'(s[0]), 32'd1);
        idx = 0;
        while (idx < nw) begin
            int k = 0;
            wait_status_ready("R6");
            while (k < 8 && idx < nw) begin
                bus_read(5'h0C, d);
                check("R5", "received word", d, exp_w[idx]);
                idx++; k++;
            end
        end
        wait_idle("R2");
        check("R5", "all receive bytes clocked", 32'(exp_mosi_q.size()), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R7", "cs lines after reset", 32'(spi_cs_n), 32'h7);
        check("R3", "SCLK idle after reset", 32'(spi_sclk), 32'd0);
        bus_read(5'h00, d); check("R1", "control after reset", d, 32'h0);
        bus_read(5'h10, d); check("R1", "status after reset", d, 32'h0);

        // R1 field readback
        bus_write(5'h08, 32'h0123);
        bus_read(5'h08, d); check("R1", "block length readback", d, 32'h0123);
        bus_write(5'h00, 32'h2000 | 32'h80 | 32'h3);
        bus_read(5'h00, d); check("R1", "control readback", d, 32'h2083);
        check("R7", "no select without start", 32'(spi_cs_n), 32'h7);

        // R4/R3: aligned transmit on select 0, rate 0
        tx_words = '{32'h4433_2211, 32'h8877_6655};
        run_write(0, 0, 8);
        check("R3", "SCLK period rate 0", 32'(last_period), 32'd4);
        check("R7", "select 0 held after block", 32'(spi_cs_n), 32'h6);

        // R4/R7: unaligned follow-on block, rate 1, same select
        tx_words = '{32'hDEAD_BEEF, 32'h0BAD_CAFE};
        run_write(0, 1, 6);
        check("R3", "SCLK period rate 1", 32'(last_period), 32'd8);
        check("R7", "select 0 still held", 32'(spi_cs_n), 32'h6);
        bus_write(5'h04, 32'h0);
        check("R7", "done releases select", 32'(spi_cs_n), 32'h7);

        // R5/R8: receive 7 bytes on select 1, rate 2
        rx_bytes = '{8'h5A, 8'hC3, 8'h01, 8'h80, 8'h7E, 8'hE7, 8'h3C};
        run_read(1, 2, 7);
        check("R3", "SCLK period rate 2", 32'(last_period), 32'd16);
        check("R7", "select 1 low", 32'(spi_cs_n), 32'h5);
        bus_read(5'h0C, d); check("R8", "empty read repeats last", d, 32'h003C_E77E);
        bus_read(5'h0C, d); check("R8", "second empty read", d, 32'h003C_E77E);
        bus_read(5'h10, d); check("R8", "status after empty reads", d, 32'h0);
        bus_write(5'h04, 32'h0);

        // R6: long transmit in two chunks on select 2
        tx_words.delete();
        for (int i = 0; i < 10; i++) tx_words.push_back(32'h1357_9BDF ^ (32'(i) * 32'h0101_0101));
        run_write(2, 0, 40);
        check("R7", "select 2 low", 32'(spi_cs_n), 32'h3);
        bus_write(5'h04, 32'h0);

        // R6: long receive in two chunks
        rx_bytes.delete();
        for (int i = 0; i < 36; i++) rx_bytes.push_back(8'(i * 7 + 3));
        run_read(1, 1, 36);
        bus_write(5'h04, 32'h0);

        // R10: control write during a slow block is ignored
        cur_req = "R10";
        tx_words = '{32'hA5C3_1E7F};
        for (int i = 0; i < 4; i++) exp_mosi_q.push_back(8'(tx_words[0] >> (8*i)));
        bus_write(5'h08, 32'd4);
        bus_write(5'h00, 32'hA000 | 32'h40 | 32'h3);
        bus_write(5'h0C, tx_words[0]);
        bus_write(5'h00, 32'h8000 | 32'h80 | 32'h0);
        bus_read(5'h00, d); check("R10", "fields kept while busy", d, 32'hA043);
        check("R10", "select unchanged while busy", 32'(spi_cs_n), 32'h5);
        wait_idle("R10");
        check("R10", "only original bytes sent", 32'(exp_mosi_q.size()), 32'd0);
        repeat (50) @(negedge clk);
        check("R10", "no second block started", 32'(rise_cnt % 8), 32'd0);
        bus_write(5'h04, 32'h0);

        // R9: zero length completes at once
        rc = rise_cnt;
        bus_write(5'h08, 32'd0);
        bus_write(5'h00, 32'h8000);
        bus_read(5'h00, d); check("R9", "busy clear after zero-length start", 32'(d[15]), 32'd0);
        repeat (20) @(negedge clk);
        check("R9", "no SCLK edges for zero length", 32'(rise_cnt), 32'(rc));
        bus_write(5'h04, 32'h0);
        check("R7", "select released at end", 32'(spi_cs_n), 32'h7);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule